// File: doc/BRIEF.md
# CPU Error Severity State Controller

This block takes hardware error reports from a processor core and decides how the core must react. Each report belongs to one of three severity classes. A fatal error stops the whole system. A state-transition error cannot be reported by a trap, so the core recovers through a watchdog reset into a reduced operating mode. An urgent error is reported to privileged software through an error trap. The block holds the processor mode (normal, error, red, fatal) and emits the one-cycle requests that carry out each recovery path.

Urgent errors come in four subtypes. Three of them come from instruction execution: instruction urgent, instruction access and data access. The fourth is autonomous and does not depend on any instruction. An instruction-obstructing error normally raises a nonmaskable trap. When the weak-detection control bit is set, the trap is suppressed for these errors. The block then signals that the damaged instruction completes with an unpredictable destination value.

When several strobes arrive in the same cycle, only the most severe class is acted on. The system controller sees a level report while the core is in fatal mode. It brings the core back with a power-on acknowledge once the system has halted.

Top module: `err_sev_ctrl`

## Requirements
- R1: After reset, `mode_o` is 00 (normal) and every request and report output is low.
- R2: A fatal strobe moves the mode to 11 (fatal) at the next clock edge from any mode. This includes the cycle of a pending watchdog request, which it cancels. `fatal_rpt_o` is high exactly while the mode is fatal, and the fatal class overrides every other strobe in the same cycle.
- R3: Fatal mode is left only when `por_ack_i` is high, and it then goes to 00. In fatal mode, all strobes other than `por_ack_i` are ignored, including `red_clr_i`. `por_ack_i` has no effect outside fatal mode.
- R4: A transition strobe without a fatal strobe, in normal (00) or red (10) mode, moves the mode to 01 (error) at the next edge and raises no trap. A transition strobe in error or fatal mode is ignored.
- R5: On the cycle after the mode becomes 01, `wdr_req_o` is high for exactly one cycle. At the edge that ends that cycle, the mode becomes 10 (red).
- R6: In red mode, `red_clr_i` returns the mode to 00. This does not happen if a fatal or transition strobe arrives in the same cycle; that strobe wins.
- R7: An instruction-obstructing strobe with `weak_det_i`=0, in mode 00 or 10, gives a one-cycle `trap_req_o` with `trap_nm_o`=1. `trap_code_o` equals `obst_code_i`, where 00 is instruction urgent, 01 is instruction access and 10 is data access. A code of 11 on this input is reported as 00.
- R8: An instruction-obstructing strobe with `weak_det_i`=1, in mode 00 or 10, gives a one-cycle `garbage_done_o` pulse and no trap.
- R9: An autonomous strobe, in mode 00 or 10, gives a one-cycle trap with `trap_code_o`=11 and `trap_nm_o`=0, whatever the value of `weak_det_i`.
- R10: When strobes coincide, the order is fatal, then transition, then urgent. Within the urgent class, an instruction-obstructing strobe wins over an autonomous one in the same cycle, and the autonomous report is dropped.
- R11: Urgent strobes that arrive while the mode is 01 or 11 cause neither a trap nor a garbage pulse.
- R12: Trap and garbage outputs are pulses one cycle wide, and they are never high together. Whenever `trap_req_o` is low, `trap_code_o` is 00 and `trap_nm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fatal_evt_i | input | 1 | Fatal error strobe |
| trans_evt_i | input | 1 | Error-state transition error strobe |
| obst_evt_i | input | 1 | Instruction-obstructing urgent error strobe |
| obst_code_i | input | 2 | Subtype of the obstructing error (00 instr, 01 instr access, 10 data access) |
| auto_evt_i | input | 1 | Autonomous urgent error strobe |
| weak_det_i | input | 1 | Weak detection control bit |
| red_clr_i | input | 1 | Software strobe that returns red mode to normal |
| por_ack_i | input | 1 | Power-on reset acknowledge from the system controller |
| mode_o | output | 2 | Processor mode: 00 normal, 01 error, 10 red, 11 fatal |
| fatal_rpt_o | output | 1 | Fatal report to the system controller |
| wdr_req_o | output | 1 | Watchdog reset request pulse |
| trap_req_o | output | 1 | Error trap request pulse |
| trap_code_o | output | 2 | Trap type code |
| trap_nm_o | output | 1 | Trap is nonmaskable |
| garbage_done_o | output | 1 | Damaged instruction completes with an unpredictable result |

## Verification
The bench targets coincident strobes. If the priority logic were wrong, it would trap on an urgent error that came with a transition or fatal error, or let an autonomous report displace an obstructing one.

It lands a fatal strobe on the exact cycle of the pending watchdog request. A design that mishandled that race would fall into red mode or leave the request high.

It sends urgent, transition, clear and acknowledge strobes into error and fatal mode, and an acknowledge into normal mode. A design that did not guard its states would raise traps there, re-arm the watchdog, or leave fatal mode without the acknowledge.

It also checks the 11 code on the obstructing input and the weak bit combined with autonomous errors. A mistake in the code mapping or in the scope of the weak bit would show up as a wrong code or a suppressed trap.

// File: rtl/err_sev_pkg.sv
package err_sev_pkg;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned TT_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ERROR  = 2'b01,
    MODE_RED    = 2'b10,
    MODE_FATAL  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SEV_NONE   = 2'b00,
    SEV_URGENT = 2'b01,
    SEV_TRANS  = 2'b10,
    SEV_FATAL  = 2'b11
  } sev_e;

  localparam logic [TT_W-1:0] TT_INSTR = 2'b00;
  localparam logic [TT_W-1:0] TT_IACC  = 2'b01;
  localparam logic [TT_W-1:0] TT_DACC  = 2'b10;
  localparam logic [TT_W-1:0] TT_AUTO  = 2'b11;

  // Urgent errors are only reported while the core can take a trap.
  function automatic logic urgent_allowed(mode_e m);
    return (m == MODE_NORMAL) || (m == MODE_RED);
  endfunction

  // Obstructing errors never carry the autonomous code.
  function automatic logic [TT_W-1:0] obst_tt(logic [TT_W-1:0] code);
    return (code == TT_AUTO) ? TT_INSTR : code;
  endfunction

  // Severity after priority: fatal > transition > urgent.
  function automatic sev_e classify(logic fatal, logic trans, logic urgent, mode_e m);
    if (fatal)                             return SEV_FATAL;
    if (trans && (m != MODE_FATAL))        return SEV_TRANS;
    if (urgent && urgent_allowed(m))       return SEV_URGENT;
    return SEV_NONE;
  endfunction

  function automatic mode_e next_mode(mode_e m, sev_e cls, logic wdr_now,
                                      logic por, logic clr);
    mode_e n;
    n = m;
    if (m == MODE_FATAL) begin
      if (por) n = MODE_NORMAL;
    end else if (cls == SEV_FATAL) begin
      n = MODE_FATAL;
    end else begin
      unique case (m)
        MODE_NORMAL: if (cls == SEV_TRANS) n = MODE_ERROR;
        MODE_ERROR:  if (wdr_now) n = MODE_RED;
        MODE_RED: begin
          if (cls == SEV_TRANS) n = MODE_ERROR;
          else if (clr)         n = MODE_NORMAL;
        end
        default: n = m;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/err_sev_classify.sv
module err_sev_classify
  import err_sev_pkg::*;
(
  input  logic  fatal_evt,
  input  logic  trans_evt,
  input  logic  obst_evt,
  input  logic  auto_evt,
  input  mode_e mode,
  output sev_e  cls,
  output logic  take_obst,
  output logic  take_auto
);

  logic urgent_any;

  always_comb begin
    urgent_any = obst_evt | auto_evt;
    cls        = classify(fatal_evt, trans_evt, urgent_any, mode);
    take_obst  = (cls == SEV_URGENT) && obst_evt;
    take_auto  = (cls == SEV_URGENT) && !obst_evt && auto_evt;
  end

endmodule

// File: rtl/err_sev_fsm.sv
module err_sev_fsm
  import err_sev_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  sev_e  cls,
  input  logic  por_ack,
  input  logic  red_clr,
  output mode_e mode,
  output logic  wdr_req,
  output logic  fatal_rpt
);

  mode_e mode_q, mode_d;
  logic  wdr_q, wdr_d;
  logic  rpt_q;
  logic  wdr_now;

  always_comb begin
    wdr_now = (mode_q == MODE_ERROR) && wdr_q;
    mode_d  = next_mode(mode_q, cls, wdr_now, por_ack, red_clr);
    wdr_d   = (mode_q == MODE_ERROR) && !wdr_q && (cls != SEV_FATAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      wdr_q  <= 1'b0;
      rpt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wdr_q  <= wdr_d;
      rpt_q  <= (mode_d == MODE_FATAL);
    end
  end

  assign mode      = mode_q;
  assign wdr_req   = wdr_q;
  assign fatal_rpt = rpt_q;

endmodule

// File: rtl/err_sev_trap.sv
module err_sev_trap
  import err_sev_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_obst,
  input  logic            take_auto,
  input  logic [TT_W-1:0] obst_code,
  input  logic            weak_det,
  output logic            trap_req,
  output logic [TT_W-1:0] trap_code,
  output logic            trap_nm,
  output logic            garbage
);

  logic            trap_d, nm_d, garb_d;
  logic [TT_W-1:0] code_d;

  always_comb begin
    trap_d = 1'b0;
    nm_d   = 1'b0;
    garb_d = 1'b0;
    code_d = '0;
    if (take_obst) begin
      if (weak_det) begin
        garb_d = 1'b1;
      end else begin
        trap_d = 1'b1;
        nm_d   = 1'b1;
        code_d = obst_tt(obst_code);
      end
    end else if (take_auto) begin
      trap_d = 1'b1;
      code_d = TT_AUTO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_code <= '0;
      trap_nm   <= 1'b0;
      garbage   <= 1'b0;
    end else begin
      trap_req  <= trap_d;
      trap_code <= code_d;
      trap_nm   <= nm_d;
      garbage   <= garb_d;
    end
  end

endmodule

// File: rtl/err_sev_ctrl.sv
module err_sev_ctrl
  import err_sev_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fatal_evt_i,
  input  logic        trans_evt_i,
  input  logic        obst_evt_i,
  input  logic [1:0]  obst_code_i,
  input  logic        auto_evt_i,
  input  logic        weak_det_i,
  input  logic        red_clr_i,
  input  logic        por_ack_i,
  output logic [1:0]  mode_o,
  output logic        fatal_rpt_o,
  output logic        wdr_req_o,
  output logic        trap_req_o,
  output logic [1:0]  trap_code_o,
  output logic        trap_nm_o,
  output logic        garbage_done_o
);

  // Named internal events, visible to the bound checker.
  sev_e  cls_w;
  mode_e mode_w;
  logic  take_obst_w;
  logic  take_auto_w;

  err_sev_classify u_cls (
    .fatal_evt (fatal_evt_i),
    .trans_evt (trans_evt_i),
    .obst_evt  (obst_evt_i),
    .auto_evt  (auto_evt_i),
    .mode      (mode_w),
    .cls       (cls_w),
    .take_obst (take_obst_w),
    .take_auto (take_auto_w)
  );

  err_sev_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls_w),
    .por_ack   (por_ack_i),
    .red_clr   (red_clr_i),
    .mode      (mode_w),
    .wdr_req   (wdr_req_o),
    .fatal_rpt (fatal_rpt_o)
  );

  err_sev_trap u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_obst (take_obst_w),
    .take_auto (take_auto_w),
    .obst_code (obst_code_i),
    .weak_det  (weak_det_i),
    .trap_req  (trap_req_o),
    .trap_code (trap_code_o),
    .trap_nm   (trap_nm_o),
    .garbage   (garbage_done_o)
  );

  assign mode_o = mode_w;

endmodule

// File: rtl/err_sev_ctrl_chk.sv
module err_sev_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fatal_evt_i,
  input logic       trans_evt_i,
  input logic       obst_evt_i,
  input logic       auto_evt_i,
  input logic       weak_det_i,
  input logic       red_clr_i,
  input logic       por_ack_i,
  input logic [1:0] mode_o,
  input logic       fatal_rpt_o,
  input logic       wdr_req_o,
  input logic       trap_req_o,
  input logic [1:0] trap_code_o,
  input logic       trap_nm_o,
  input logic       garbage_done_o
);

  logic may_trap;
  assign may_trap = (mode_o == 2'b00) || (mode_o == 2'b10);

  a_r2_fatal_enter: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_evt_i |=> (mode_o == 2'b11));

  a_r2_report_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_rpt_o == (mode_o == 2'b11));

  a_r3_fatal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) && !por_ack_i |=> (mode_o == 2'b11));

  a_r3_fatal_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) && por_ack_i |=> (mode_o == 2'b00));

  a_r4_trans_enter: assert property (@(posedge clk) disable iff (!rst_n)
    trans_evt_i && !fatal_evt_i && may_trap
    |=> (mode_o == 2'b01) && !trap_req_o && !garbage_done_o);

  a_r5_wdr_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) && !wdr_req_o && !fatal_evt_i |=> wdr_req_o);

  a_r5_red_after: assert property (@(posedge clk) disable iff (!rst_n)
    wdr_req_o && !fatal_evt_i |=> (mode_o == 2'b10) && !wdr_req_o);

  a_r6_red_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) && red_clr_i && !fatal_evt_i && !trans_evt_i
    |=> (mode_o == 2'b00));

  a_r7_obst_trap: assert property (@(posedge clk) disable iff (!rst_n)
    obst_evt_i && !weak_det_i && !fatal_evt_i && !trans_evt_i && may_trap
    |=> trap_req_o && trap_nm_o && (trap_code_o != 2'b11));

  a_r8_weak_garbage: assert property (@(posedge clk) disable iff (!rst_n)
    obst_evt_i && weak_det_i && !fatal_evt_i && !trans_evt_i && may_trap
    |=> garbage_done_o && !trap_req_o);

  a_r9_auto_code: assert property (@(posedge clk) disable iff (!rst_n)
    auto_evt_i && !obst_evt_i && !fatal_evt_i && !trans_evt_i && may_trap
    |=> trap_req_o && (trap_code_o == 2'b11) && !trap_nm_o);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !may_trap |=> !trap_req_o && !garbage_done_o);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req_o && garbage_done_o));

  a_r12_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req_o |-> (trap_code_o == 2'b00) && !trap_nm_o);

endmodule

bind err_sev_ctrl err_sev_ctrl_chk u_chk (.*);

// File: tb/err_sev_ctrl_tb_top.sv
module err_sev_ctrl_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fatal_evt_i = 0, trans_evt_i = 0, obst_evt_i = 0, auto_evt_i = 0;
  logic [1:0] obst_code_i = 0;
  logic       weak_det_i = 0, red_clr_i = 0, por_ack_i = 0;
  logic [1:0] mode_o, trap_code_o;
  logic       fatal_rpt_o, wdr_req_o, trap_req_o, trap_nm_o, garbage_done_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_sev_ctrl dut_i (.*);

  // Stimulus {fatal,trans,obst,auto,code[1:0],weak}
  // Expected {mode[1:0],trap,code[1:0],nm,garbage}; every row starts in normal mode.
  localparam int NV = 12;
  localparam logic [13:0] VECS [NV] = '{
    {7'b0010010, 7'b0010110},  // R7 instr access, nonmaskable
    {7'b0010101, 7'b0000001},  // R8 weak: garbage, no trap
    {7'b0001000, 7'b0011100},  // R9 autonomous
    {7'b0001001, 7'b0011100},  // R9 weak bit does not touch autonomous
    {7'b0011000, 7'b0010010},  // R10 obstructing beats autonomous
    {7'b0010110, 7'b0010010},  // R7 code 11 reported as 00
    {7'b0110010, 7'b0100000},  // R10 transition beats urgent (R4)
    {7'b1101000, 7'b1100000},  // R10 fatal beats all (R2)
    {7'b0000000, 7'b0000000},  // R12 idle stays quiet
    {7'b1010001, 7'b1100000},  // R2 fatal beats weak obstructing
    {7'b0010100, 7'b0011010},  // R7 data access
    {7'b0101000, 7'b0100000}   // R4 transition drops autonomous
  };

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {mode,rpt,wdr,trap,code,nm,garbage}
  function automatic logic [15:0] outs();
    return {7'd0, mode_o, fatal_rpt_o, wdr_req_o, trap_req_o, trap_code_o, trap_nm_o, garbage_done_o};
  endfunction

  function automatic logic [15:0] want(logic [1:0] m, logic w, logic t, logic [1:0] c,
                                       logic n, logic g);
    return {7'd0, m, (m == 2'b11), w, t, c, n, g};
  endfunction

  task automatic clear_in();
    {fatal_evt_i, trans_evt_i, obst_evt_i, auto_evt_i, weak_det_i, red_clr_i, por_ack_i} = '0;
    obst_code_i = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    do_reset();
    check("R1", "reset state", outs(), want(2'b00, 0, 0, 2'b00, 0, 0));

    // Table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      {fatal_evt_i, trans_evt_i, obst_evt_i, auto_evt_i, obst_code_i, weak_det_i} = VECS[i][13:7];
      @(posedge clk);
      @(negedge clk);
      clear_in();
      check("R2/R4/R7/R8/R9/R10", $sformatf("vector %0d", i), outs(),
            want(VECS[i][6:5], 0, VECS[i][4], VECS[i][3:2], VECS[i][1], VECS[i][0]));
      tick();
      if (VECS[i][6:5] != 2'b01)
        check("R12", $sformatf("vector %0d pulse ends", i), {14'd0, trap_req_o, garbage_done_o}, 16'd0);
    end

    // Transition path: error, watchdog pulse, red
    do_reset();
    trans_evt_i = 1; tick();
    check("R4", "enter error, no trap", outs(), want(2'b01, 0, 0, 2'b00, 0, 0));
    // In error with watchdog pending: urgent and transition strobes ignored
    trans_evt_i = 1; obst_evt_i = 1; auto_evt_i = 1; tick();
    check("R5", "watchdog pulse", outs(), want(2'b01, 1, 0, 2'b00, 0, 0));
    check("R11", "urgent ignored in error", {14'd0, trap_req_o, garbage_done_o}, 16'd0);
    obst_evt_i = 1; tick();
    check("R5", "red after watchdog", outs(), want(2'b10, 0, 0, 2'b00, 0, 0));
    check("R11", "urgent ignored on last error cycle", {14'd0, trap_req_o, garbage_done_o}, 16'd0);

    // Red mode still takes traps
    obst_evt_i = 1; obst_code_i = 2'b10; tick();
    check("R7", "trap from red", outs(), want(2'b10, 0, 1, 2'b10, 1, 0));
    // Clear loses to transition
    red_clr_i = 1; trans_evt_i = 1; tick();
    check("R6", "transition wins over clear", outs(), want(2'b01, 0, 0, 2'b00, 0, 0));
    tick(); tick();
    check("R5", "back in red", mode_o, 16'd2);
    red_clr_i = 1; tick();
    check("R6", "clear to normal", outs(), want(2'b00, 0, 0, 2'b00, 0, 0));

    // Fatal landing on the watchdog cycle
    trans_evt_i = 1; tick();
    fatal_evt_i = 1; tick();
    check("R2", "fatal during error", outs(), want(2'b11, 0, 0, 2'b00, 0, 0));
    // Everything but the acknowledge is ignored in fatal
    trans_evt_i = 1; auto_evt_i = 1; obst_evt_i = 1; red_clr_i = 1; tick();
    check("R3", "fatal holds against strobes", outs(), want(2'b11, 0, 0, 2'b00, 0, 0));
    check("R11", "urgent ignored in fatal", {14'd0, trap_req_o, garbage_done_o}, 16'd0);
    repeat (5) tick();
    check("R3", "fatal holds idle", outs(), want(2'b11, 0, 0, 2'b00, 0, 0));
    por_ack_i = 1; tick();
    check("R3", "acknowledge exits fatal", outs(), want(2'b00, 0, 0, 2'b00, 0, 0));
    por_ack_i = 1; tick();
    check("R3", "acknowledge ignored in normal", outs(), want(2'b00, 0, 0, 2'b00, 0, 0));

    // Fatal from red, and back-to-back urgent traps
    trans_evt_i = 1; tick(); tick(); tick();
    fatal_evt_i = 1; red_clr_i = 1; tick();
    check("R2", "fatal from red beats clear", outs(), want(2'b11, 0, 0, 2'b00, 0, 0));
    por_ack_i = 1; tick();
    obst_evt_i = 1; obst_code_i = 2'b00; tick();
    check("R7", "instr urgent trap", outs(), want(2'b00, 0, 1, 2'b00, 1, 0));
    auto_evt_i = 1; weak_det_i = 1; tick();
    check("R9", "consecutive autonomous trap", outs(), want(2'b00, 0, 1, 2'b11, 0, 0));
    tick();
    check("R12", "idle after traps", outs(), want(2'b00, 0, 0, 2'b00, 0, 0));

    finish_up();
  end

endmodule